// File: doc/BRIEF.md
# Lockout Edge Deglitcher

This block cleans a digital input that rings for a short time after each real transition, for example a comparator output fed by a damped resonance. A low-pass debouncer waits until the input has been stable for its whole filter time before it reacts. This block does the opposite. It passes the first edge of each transition to its output after a short fixed delay. It then stops listening to the input for a blanking window whose length software sets as a number of clock cycles.

The controller moves through four phases in a fixed order: wait for a high level, hold high while blanking, wait for a low level, hold low while blanking. The raw input first goes through a two-stage synchronizer. The registered outputs are a clean level and one-cycle rise and fall strobes that line up with each change of that level. In the retriggerable mode, every input transition seen during a hold restarts the blanking window. The hold therefore lasts until the input has been quiet for the full window. The block keeps no history beyond the current phase and counter, so the input rate has no effect on its behaviour.

Top module: `edge_lockout_deglitch`

## Requirements
- R1: While `rst_ni` is low, `clean_o`, `rise_o` and `fall_o` are 0 and the block waits for a high input level.
- R2: When the block is waiting for a high level and `raw_i` goes high, `clean_o` rises exactly three clock edges after the first edge that samples the new value. Those three edges are two synchronizer stages and one output register.
- R3: After `clean_o` changes, it holds for at least `blank_len_i + 2` cycles. Input transitions inside the blanking window do not change the output.
- R4: After a high hold ends, only a low input level is accepted. The fall follows with the same three-edge latency as R2 and starts a blanking window of the same kind.
- R5: With `blank_len_i` = 0, the hold lasts one cycle, so a clean pulse is at least 2 cycles wide.
- R6: With `retrig_i` = 1, every transition of the synchronized input during a hold reloads the window. The output can then change at the earliest `blank_len_i + 5` cycles after the last raw transition, counted from the cycle in which that transition was driven.
- R7: If the synchronized input already differs from `clean_o` when a hold ends, the new level is accepted on the next cycle. A transition that happened during blanking is never lost.
- R8: `rise_o` (or `fall_o`) is high for exactly the one cycle in which `clean_o` goes from 0 to 1 (or from 1 to 0). The two strobes are never high together.
- R9: Behaviour does not depend on how long the input was idle before. An edge after thousands of quiet cycles is handled the same way as one after a short gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Raw, asynchronous, ringing input |
| blank_len_i | input | CNT_W | Blanking window length in clock cycles |
| retrig_i | input | 1 | 1: transitions during a hold restart the window |
| clean_o | output | 1 | Deglitched level |
| rise_o | output | 1 | One-cycle strobe on a rising clean edge |
| fall_o | output | 1 | One-cycle strobe on a falling clean edge |

## Verification
The bench builds the block with the default 16-bit counter and two synchronizer stages. It sets the blanking length to 6 and to 0 at run time, so the end of each window falls only a few cycles after the accepted edge. This makes every post-window acceptance land on an exact cycle the bench can predict. The short windows also make the retriggerable and fixed modes produce different, easily predicted fall cycles for the same ringing burst. Idle stretches of several thousand cycles are placed between edges to check that the block keeps no history.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  typedef enum logic [1:0] {
    PH_WAIT_HI = 2'd0,
    PH_HOLD_HI = 2'd1,
    PH_WAIT_LO = 2'd2,
    PH_HOLD_LO = 2'd3
  } phase_e;

endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic toggle_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= raw_i;
        else             chain_q[i] <= chain_q[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[LAST];
  end

  assign level_o  = chain_q[LAST];
  assign toggle_o = chain_q[LAST] ^ prev_q;

endmodule

// File: rtl/dg_blank_timer.sv
module dg_blank_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= len_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R6: a load always takes the length presented in that cycle
  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(len_i)));

  // R3: the window does not run out while a nonzero count is still pending
  p_no_early_expiry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !expired_o && cnt_q != 1) |=> !expired_o);

endmodule

// File: rtl/dg_phase_ctrl.sv
module dg_phase_ctrl
  import deglitch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic toggle_i,
  input  logic retrig_i,
  input  logic expired_i,
  output logic load_o,
  output logic dec_o,
  output logic clean_o,
  output logic rise_o,
  output logic fall_o
);

  phase_e phase_q, phase_d;
  logic   out_q, out_d;
  logic   rise_q, rise_d;
  logic   fall_q, fall_d;
  logic   holding;
  logic   restart;

  assign holding = (phase_q == PH_HOLD_HI) || (phase_q == PH_HOLD_LO);
  assign restart = holding && retrig_i && toggle_i;

  always_comb begin
    phase_d = phase_q;
    out_d   = out_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    unique case (phase_q)
      PH_WAIT_HI: if (level_i) begin
        out_d   = 1'b1;
        rise_d  = 1'b1;
        load_o  = 1'b1;
        phase_d = PH_HOLD_HI;
      end
      PH_WAIT_LO: if (!level_i) begin
        out_d   = 1'b0;
        fall_d  = 1'b1;
        load_o  = 1'b1;
        phase_d = PH_HOLD_LO;
      end
      PH_HOLD_HI, PH_HOLD_LO: begin
        if (restart)        load_o  = 1'b1;
        else if (expired_i) phase_d = (phase_q == PH_HOLD_HI) ? PH_WAIT_LO : PH_WAIT_HI;
        else                dec_o   = 1'b1;
      end
      default: phase_d = PH_WAIT_HI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT_HI;
      out_q   <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      out_q   <= out_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign clean_o = out_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

  p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_q && fall_q));

  p_rise_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> (out_q && !$past(out_q)));

  p_fall_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> (!out_q && $past(out_q)));

  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holding |=> $stable(out_q));

  // R5: an exhausted window without restart leaves the hold on the next cycle
  p_expire_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holding && expired_i && !restart) |=> !holding);

  // R7: in a wait phase a mismatching level is taken at once
  p_wait_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!holding && (level_i != out_q)) |=> (out_q != $past(out_q)));

endmodule

// File: rtl/edge_lockout_deglitch.sv
module edge_lockout_deglitch #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] blank_len_i,
  input  logic             retrig_i,
  output logic             clean_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic level, toggle, load, dec, expired;

  dg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (raw_i),
    .level_o  (level),
    .toggle_o (toggle)
  );

  dg_blank_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .dec_i     (dec),
    .len_i     (blank_len_i),
    .expired_o (expired)
  );

  dg_phase_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .toggle_i  (toggle),
    .retrig_i  (retrig_i),
    .expired_i (expired),
    .load_o    (load),
    .dec_o     (dec),
    .clean_o   (clean_o),
    .rise_o    (rise_o),
    .fall_o    (fall_o)
  );

endmodule

// File: tb/test_edge_lockout_deglitch.sv
module test_edge_lockout_deglitch;

  localparam int unsigned CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             raw_i = 1'b0;
  logic [CNT_W-1:0] blank_len_i = 16'd6;
  logic             retrig_i = 1'b0;
  logic             clean_o, rise_o, fall_o;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    bit    is_rise;
    int    at;
    string req;
  } ev_t;

  ev_t exp_q[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  edge_lockout_deglitch #(.CNT_W(CNT_W)) i_edge_lockout_deglitch (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw_i), .blank_len_i(blank_len_i),
    .retrig_i(retrig_i), .clean_o(clean_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  // drive raw_i in the current cycle; returns that cycle number
  task automatic drive(input logic v, output int c);
    @(negedge clk_i);
    raw_i = v;
    c = cyc;
  endtask

  task automatic push(input bit is_rise, input int at, input string req);
    ev_t e;
    e.is_rise = is_rise;
    e.at = at;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: pops expected strobes and compares kind, cycle and level
  always @(negedge clk_i) begin
    if (rst_ni && (rise_o || fall_o)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected strobe", {30'd0, rise_o, fall_o}, 0);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(rise_o == e.is_rise && fall_o == !e.is_rise, {e.req, " strobe kind"},
            int'(rise_o), int'(e.is_rise));
        chk(cyc == e.at, {e.req, " strobe cycle"}, cyc, e.at);
        chk(clean_o == e.is_rise, "R8 level with strobe", int'(clean_o), int'(e.is_rise));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int c, d;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!clean_o && !rise_o && !fall_o, "R1 reset outputs", {29'd0, clean_o, rise_o, fall_o}, 0);
    rst_ni = 1'b1;
    idle(5);
    chk(clean_o == 1'b0, "R1 idle after reset", int'(clean_o), 0);

    // R2/R3: first rise passes, ringing ending high is ignored
    drive(1'b1, c); push(1'b1, c + 3, "R2");
    drive(1'b0, d); drive(1'b1, d); drive(1'b0, d); drive(1'b1, d);
    idle(20);
    chk(clean_o == 1'b1, "R3 held high after ringing", int'(clean_o), 1);

    // R4: clean fall after the hold
    drive(1'b0, c); push(1'b0, c + 3, "R4");
    idle(20);

    // R7 high side: input drops inside the window, fall at window end (N=6)
    drive(1'b1, c); push(1'b1, c + 3, "R2");
    drive(1'b0, d); push(1'b0, c + 11, "R7");
    idle(20);

    // R7 low side: ringing after a fall ends high, rise at window end
    drive(1'b1, c); push(1'b1, c + 3, "R2");
    idle(20);
    drive(1'b0, c); push(1'b0, c + 3, "R4");
    drive(1'b1, d); drive(1'b0, d); drive(1'b1, d); push(1'b1, c + 11, "R7");
    idle(20);
    drive(1'b0, c); push(1'b0, c + 3, "R4");
    idle(20);

    // R6: retriggerable mode stretches the hold past the last transition
    retrig_i = 1'b1;
    drive(1'b1, c); push(1'b1, c + 3, "R2");
    drive(1'b0, d); drive(1'b1, d); drive(1'b0, d); push(1'b0, d + 11, "R6");
    idle(25);
    drive(1'b1, c); push(1'b1, c + 3, "R2");
    idle(20);
    drive(1'b0, c); push(1'b0, c + 3, "R4");
    drive(1'b1, d); drive(1'b0, d); drive(1'b1, d); push(1'b1, d + 11, "R6");
    idle(25);
    drive(1'b0, c); push(1'b0, c + 3, "R4");
    idle(20);
    retrig_i = 1'b0;

    // R5: zero-length window gives a two-cycle pulse
    blank_len_i = '0;
    idle(2);
    drive(1'b1, c); push(1'b1, c + 3, "R5");
    drive(1'b0, d); push(1'b0, c + 5, "R5");
    idle(20);
    chk(clean_o == 1'b0, "R5 low after short pulse", int'(clean_o), 0);

    // R9: long idle gaps behave the same
    blank_len_i = 16'd6;
    idle(3000);
    drive(1'b1, c); push(1'b1, c + 3, "R9");
    drive(1'b0, d); drive(1'b1, d);
    idle(5000);
    chk(clean_o == 1'b1, "R9 high after long idle", int'(clean_o), 1);
    drive(1'b0, c); push(1'b0, c + 3, "R9");
    idle(20);

    chk(exp_q.size() == 0, "R8 all expected strobes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule